// File: doc/BRIEF.md
# Indirect Codec Register Access Bridge

This block lets a host bus reach a bank of 8-bit internal configuration registers through two 32-bit windows. The host writes a command word holding a 7-bit internal address, an 8-bit data byte and a write-request bit. A second window returns the byte selected by the most recently loaded address, together with an interrupt indication.

An internal write keeps the write-request bit reading as 1 for a fixed number of cycles. During that time the bridge refuses any new command. A read is started by loading an address with the request bit clear. The returned byte changes only after a fixed settling count has run out, and until then the previous byte stays on the window.

The bank holds 28 registers, each with its own reset value. Two of them are test registers that cannot be reached, and addresses past the end of the bank are not decoded. One register collects ramp-completion events from hardware, and these events drive the interrupt.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset the command window reads 0. The read window shows 0x0c, which is the reset value of address 0, and `irq` is 0.
- R2: The command window sits at byte offset 0x00. Its bit 16 is the write request / busy bit, bits 14:8 are the address, bits 7:0 are the data, and every other bit reads 0. The read window sits at offset 0x04. Its bits 7:0 are the read byte, bit 8 is the interrupt, and every other bit reads 0. Any other offset reads 0, and a host write to any offset other than 0x00 has no effect.
- R3: An idle command write with bit 16 set stores bits 7:0 into the register at bits 14:8. The busy bit then reads 1 for exactly BUSY_CYC cycles after the write edge and 0 after that.
- R4: A command write while busy is ignored: address, data and register contents stay unchanged.
- R5: A command write with bit 16 clear loads the address and data fields and changes no register.
- R6: After an accepted command write, the read byte keeps its previous value for SETTLE_CYC-1 cycles. It shows the newly addressed register's value from the SETTLE_CYC-th edge on.
- R7: Addresses 20 and 21, and any address of 28 or above, ignore writes and read as 0.
- R8: Reset values of addresses 0 to 27: 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00.
- R9: A pulse on `ramp_up_evt` sets bit 3 of register 9, and a pulse on `ramp_dn_evt` sets bit 2. A host write to register 9 in the same cycle does not clear a bit that is being set.
- R10: `irq` and read-window bit 8 equal the OR of all bits of register 9. A host write of 0 to register 9 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Window contents selected by host_addr |
| ramp_up_evt | input | 1 | Ramp-up completion event |
| ramp_dn_evt | input | 1 | Ramp-down completion event |
| irq | output | 1 | OR of the event flag register bits |

## Verification
The bench builds the bridge with BUSY_CYC=5 and SETTLE_CYC=7 instead of the defaults. This shows that both counts follow the parameters and are not fixed at 4 and 6. With these values the busy window is shorter than the settling window, so one command write exercises the end of busy and the end of settling at different edges. A stray second command inside the busy period can also be checked against both counters.

// File: rtl/codec_reg_bridge_pkg.sv
`timescale 1ns/1ps
package codec_reg_bridge_pkg;
    localparam int IDX_W       = 7;
    localparam int BYTE_W      = 8;
    localparam int BANK_SIZE   = 28;
    localparam int FLAG_REG    = 9;
    localparam int TEST_LO     = 20;
    localparam int TEST_HI     = 21;
    localparam int RAMP_UP_BIT = 3;
    localparam int RAMP_DN_BIT = 2;
    localparam int WREQ_BIT    = 16;
    localparam int ADDR_LSB    = 8;
    localparam int IRQ_BIT     = 8;
    localparam int CMD_OFFSET  = 0;
    localparam int DATA_OFFSET = 4;

    function automatic logic [BYTE_W-1:0] reset_value(input int unsigned idx);
        case (idx)
            0:  return 8'h0c;  1: return 8'haa;  2: return 8'h78;  5: return 8'hff;
            6:  return 8'h03;  7: return 8'h51;  8: return 8'h3f;
            11, 12, 13, 14, 15, 16: return 8'h04;
            17, 18: return 8'h0a;
            22: return 8'hc0; 23: return 8'h34; 24: return 8'h07;
            25: return 8'h44; 26: return 8'h1f;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic reg_present(input logic [IDX_W-1:0] a);
        return (int'(a) < BANK_SIZE) && (int'(a) != TEST_LO) && (int'(a) != TEST_HI);
    endfunction
endpackage

// File: rtl/crb_cmd_ctrl.sv
`timescale 1ns/1ps
module crb_cmd_ctrl
    import codec_reg_bridge_pkg::*;
#(
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic              cmd_wreq,
    input  logic [IDX_W-1:0]  cmd_addr,
    input  logic [BYTE_W-1:0] cmd_data,
    output logic              accept,
    output logic              wr_stb,
    output logic              busy,
    output logic [IDX_W-1:0]  cur_addr,
    output logic [BYTE_W-1:0] cur_data
);
    localparam int CW = $clog2(BUSY_CYC + 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [IDX_W-1:0]  addr;
        logic [BYTE_W-1:0] data;
    } cmd_st_t;

    cmd_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = cmd_wr && (st_q.cnt == '0);
        wr_stb = accept && cmd_wreq;
        if (accept) begin
            st_d.addr = cmd_addr;
            st_d.data = cmd_data;
        end
        if (wr_stb) begin
            st_d.cnt = CW'(BUSY_CYC);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = (st_q.cnt != '0);
    assign cur_addr = st_q.addr;
    assign cur_data = st_q.data;
endmodule

// File: rtl/crb_regbank.sv
`timescale 1ns/1ps
module crb_regbank
    import codec_reg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              up_evt,
    input  logic              dn_evt,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_view,
    output logic              flag_any
);
    typedef struct packed {
        logic [BANK_SIZE-1:0][BYTE_W-1:0] r;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < BANK_SIZE; i++) begin
            if (wr_stb && (wr_addr == IDX_W'(i)) && reg_present(wr_addr))
                st_d.r[i] = wr_data;
        end
        // hardware events win over a host write in the same cycle
        st_d.r[FLAG_REG][RAMP_UP_BIT] = st_d.r[FLAG_REG][RAMP_UP_BIT] | up_evt;
        st_d.r[FLAG_REG][RAMP_DN_BIT] = st_d.r[FLAG_REG][RAMP_DN_BIT] | dn_evt;
    end

    always_comb begin
        rd_view = '0;
        for (int i = 0; i < BANK_SIZE; i++) begin
            if ((rd_addr == IDX_W'(i)) && reg_present(rd_addr))
                rd_view = st_q.r[i];
        end
    end

    assign flag_any = |st_q.r[FLAG_REG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BANK_SIZE; i++) st_q.r[i] <= reset_value(i);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/crb_read_pipe.sv
`timescale 1ns/1ps
module crb_read_pipe
    import codec_reg_bridge_pkg::*;
#(
    parameter int SETTLE_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] view,
    output logic [BYTE_W-1:0] rd_word
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] word;
    } rd_st_t;

    rd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = CW'(SETTLE_CYC);
        end else begin
            if (st_q.cnt <= CW'(1)) st_d.word = view;
            if (st_q.cnt != '0)     st_d.cnt  = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.word <= reset_value(0);
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_word = st_q.word;
endmodule

// File: rtl/codec_reg_bridge.sv
`timescale 1ns/1ps
module codec_reg_bridge
    import codec_reg_bridge_pkg::*;
#(
    parameter int HOST_AW    = 4,
    parameter int BUSY_CYC   = 4,
    parameter int SETTLE_CYC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    input  logic               ramp_up_evt,
    input  logic               ramp_dn_evt,
    output logic               irq
);
    logic              sel_cmd, sel_dat;
    logic              accept_w, wr_stb_w, busy_w;
    logic [IDX_W-1:0]  cur_addr_w;
    logic [BYTE_W-1:0] cur_data_w, view_w, rd_word_w;

    assign sel_cmd = (host_addr == HOST_AW'(CMD_OFFSET));
    assign sel_dat = (host_addr == HOST_AW'(DATA_OFFSET));

    crb_cmd_ctrl #(.BUSY_CYC(BUSY_CYC)) cmd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (host_wr && sel_cmd),
        .cmd_wreq (host_wdata[WREQ_BIT]),
        .cmd_addr (host_wdata[ADDR_LSB +: IDX_W]),
        .cmd_data (host_wdata[BYTE_W-1:0]),
        .accept   (accept_w),
        .wr_stb   (wr_stb_w),
        .busy     (busy_w),
        .cur_addr (cur_addr_w),
        .cur_data (cur_data_w)
    );

    crb_regbank bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb_w),
        .wr_addr  (host_wdata[ADDR_LSB +: IDX_W]),
        .wr_data  (host_wdata[BYTE_W-1:0]),
        .up_evt   (ramp_up_evt),
        .dn_evt   (ramp_dn_evt),
        .rd_addr  (cur_addr_w),
        .rd_view  (view_w),
        .flag_any (irq)
    );

    crb_read_pipe #(.SETTLE_CYC(SETTLE_CYC)) rdp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept_w),
        .view    (view_w),
        .rd_word (rd_word_w)
    );

    always_comb begin
        host_rdata = '0;
        if (sel_cmd) begin
            host_rdata[WREQ_BIT]              = busy_w;
            host_rdata[ADDR_LSB +: IDX_W]     = cur_addr_w;
            host_rdata[BYTE_W-1:0]            = cur_data_w;
        end else if (sel_dat) begin
            host_rdata[IRQ_BIT]               = irq;
            host_rdata[BYTE_W-1:0]            = rd_word_w;
        end
    end
endmodule

// File: rtl/codec_reg_bridge_chk.sv
`timescale 1ns/1ps
module codec_reg_bridge_chk #(
    parameter int HOST_AW    = 4,
    parameter int SETTLE_CYC = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [31:0]        host_wdata,
    input logic [31:0]        host_rdata,
    input logic               ramp_up_evt,
    input logic               irq,
    input logic               busy_w,
    input logic               accept_w,
    input logic [6:0]         cur_addr_w,
    input logic [7:0]         cur_data_w,
    input logic [7:0]         rd_word_w
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    logic [CW-1:0] own_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              own_cnt <= '0;
        else if (accept_w)       own_cnt <= CW'(SETTLE_CYC);
        else if (own_cnt != '0)  own_cnt <= own_cnt - 1'b1;
    end

    assert_busy_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == '0 && host_wdata[16] && !busy_w) |=> busy_w);

    assert_busy_ignores_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == '0 && busy_w) |=> ($stable(cur_addr_w) && $stable(cur_data_w)));

    assert_read_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_w || own_cnt > CW'(1)) |=> $stable(rd_word_w));

    assert_up_event_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_up_evt |=> irq);

    assert_window_zero_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == HOST_AW'(4)) |-> (host_rdata[31:9] == '0));

    assert_other_offset_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr != '0 && host_addr != HOST_AW'(4)) |-> (host_rdata == '0));
endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(
    .HOST_AW    (HOST_AW),
    .SETTLE_CYC (SETTLE_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .ramp_up_evt (ramp_up_evt),
    .irq         (irq),
    .busy_w      (busy_w),
    .accept_w    (accept_w),
    .cur_addr_w  (cur_addr_w),
    .cur_data_w  (cur_data_w),
    .rd_word_w   (rd_word_w)
);

// File: tb/codec_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module codec_reg_bridge_tb_top;
    localparam int AW     = 4;
    localparam int BUSY   = 5;
    localparam int SETTLE = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          ramp_up_evt = 1'b0;
    logic          ramp_dn_evt = 1'b0;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [28];
    logic [6:0] last_addr = '0;

    always #5 clk = ~clk;

    codec_reg_bridge #(.HOST_AW(AW), .BUSY_CYC(BUSY), .SETTLE_CYC(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .ramp_up_evt(ramp_up_evt), .ramp_dn_evt(ramp_dn_evt), .irq(irq)
    );

    function automatic logic [7:0] dflt(input int i);
        logic [7:0] t [28] = '{8'h0c,8'haa,8'h78,8'h00,8'h00,8'hff,8'h03,8'h51,
                               8'h3f,8'h00,8'h00,8'h04,8'h04,8'h04,8'h04,8'h04,
                               8'h04,8'h0a,8'h0a,8'h00,8'h00,8'h00,8'hc0,8'h34,
                               8'h07,8'h44,8'h1f,8'h00};
        return t[i];
    endfunction

    function automatic bit present(input logic [6:0] a);
        return (a < 7'd28) && (a != 7'd20) && (a != 7'd21);
    endfunction

    function automatic logic [7:0] view_exp(input logic [6:0] a);
        return present(a) ? model[a] : 8'h00;
    endfunction

    function automatic logic [31:0] cmd_word(input bit w, input logic [6:0] a, input logic [7:0] d);
        return {15'b0, w, 1'b0, a, d};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [AW-1:0] off, output logic [31:0] v);
        host_addr = off;
        #1;
        v = host_rdata;
    endtask

    task automatic bus_write(input logic [AW-1:0] off, input logic [31:0] w);
        host_addr  = off;
        host_wdata = w;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    // full internal write with exact busy timing (R3)
    task automatic write_reg(input logic [6:0] a, input logic [7:0] d);
        logic [31:0] v;
        bus_write(0, cmd_word(1'b1, a, d));
        if (present(a)) model[a] = d;
        last_addr = a;
        peek(0, v);
        chk("R3 busy after write", {31'b0, v[16]}, 32'd1);
        for (int i = 1; i < BUSY; i++) begin
            @(negedge clk);
            peek(0, v);
            chk("R3 busy held", {31'b0, v[16]}, 32'd1);
        end
        @(negedge clk);
        peek(0, v);
        chk("R3 busy cleared / R2 cmd window", v, cmd_word(1'b0, a, d));
        repeat (SETTLE) @(negedge clk);
        peek(4, v);
        chk("R3 write readback", v, {23'b0, |model[9], view_exp(a)});
    endtask

    // address-only read with exact latency (R6)
    task automatic read_reg(input logic [6:0] a, input string req);
        logic [31:0] v;
        logic [7:0]  old;
        old = view_exp(last_addr);
        bus_write(0, cmd_word(1'b0, a, 8'h00));
        last_addr = a;
        repeat (SETTLE - 1) @(negedge clk);
        peek(4, v);
        chk("R6 previous word held", {24'b0, v[7:0]}, {24'b0, old});
        @(negedge clk);
        peek(4, v);
        chk(req, {24'b0, v[7:0]}, {24'b0, view_exp(a)});
        chk("R10 read bit 8", {31'b0, v[8]}, {31'b0, |model[9]});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 28; i++) model[i] = dflt(i);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(0, v); chk("R1 cmd window", v, 32'h0);
        peek(4, v); chk("R1 read window", v, 32'h0000_000c);
        chk("R1 irq", {31'b0, irq}, 32'd0);

        // R8 / R7 defaults of every address
        for (int a = 0; a < 28; a++) read_reg(7'(a), (a == 20 || a == 21) ? "R7 test reg reads 0" : "R8 default");

        // R2 other offsets
        peek(8, v); chk("R2 unmapped offset", v, 32'h0);
        bus_write(4, cmd_word(1'b1, 7'd3, 8'h99));
        peek(0, v); chk("R2 write to read window ignored", v, cmd_word(1'b0, 7'd27, 8'h00));
        bus_write(12, cmd_word(1'b1, 7'd3, 8'h99));
        repeat (SETTLE) @(negedge clk);
        read_reg(7'd3, "R2 stray write left reg 3");

        // R5 address-only command
        bus_write(0, cmd_word(1'b0, 7'd1, 8'h99));
        last_addr = 7'd1;
        peek(0, v); chk("R5 fields loaded no busy", v, cmd_word(1'b0, 7'd1, 8'h99));
        repeat (SETTLE) @(negedge clk);
        peek(4, v); chk("R5 reg 1 unchanged", {24'b0, v[7:0]}, 32'h0000_00aa);

        // R4 command while busy
        bus_write(0, cmd_word(1'b1, 7'd2, 8'h11));
        model[2] = 8'h11;
        bus_write(0, cmd_word(1'b1, 7'd3, 8'h77));
        peek(0, v); chk("R4 fields kept while busy", v, cmd_word(1'b1, 7'd2, 8'h11));
        last_addr = 7'd2;
        repeat (BUSY + SETTLE) @(negedge clk);
        read_reg(7'd3, "R4 reg 3 untouched");
        read_reg(7'd2, "R4 first write landed");

        // R7 filtered writes
        write_reg(7'd20, 8'h5a);
        read_reg(7'd20, "R7 test reg write ignored");
        write_reg(7'd100, 8'hff);
        read_reg(7'd100, "R7 high address reads 0");
        read_reg(7'd4, "R7 no aliasing into reg 4");

        // R9 / R10 events
        ramp_up_evt = 1'b1;
        @(negedge clk);
        ramp_up_evt = 1'b0;
        model[9][3] = 1'b1;
        chk("R10 irq after ramp-up", {31'b0, irq}, 32'd1);
        read_reg(7'd9, "R9 ramp-up sets bit 3");
        write_reg(7'd9, 8'h00);
        chk("R10 irq cleared by write", {31'b0, irq}, 32'd0);
        host_addr  = 0;
        host_wdata = cmd_word(1'b1, 7'd9, 8'h00);
        host_wr    = 1'b1;
        ramp_dn_evt = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
        ramp_dn_evt = 1'b0;
        model[9] = 8'h04;
        repeat (BUSY + SETTLE) @(negedge clk);
        read_reg(7'd9, "R9 set beats same-cycle clear");
        chk("R10 irq from ramp-down", {31'b0, irq}, 32'd1);
        write_reg(7'd9, 8'h00);

        // random mix
        for (int n = 0; n < 120; n++) begin
            logic [6:0] a;
            logic [7:0] d;
            a = ($urandom_range(0, 7) == 0) ? 7'($urandom_range(28, 127)) : 7'($urandom_range(0, 27));
            d = 8'($urandom);
            if ($urandom_range(0, 1) == 1) write_reg(a, d);
            else read_reg(a, "R6 random read");
            chk("R10 irq tracks reg 9", {31'b0, irq}, {31'b0, |model[9]});
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule